// File: doc/BRIEF.md
# DMA Request Descriptor Sequencer

This block takes one request descriptor at a time from a request queue and carries out its data-movement part. It reads the packed command byte to find the transfer kind, the transfer mode and the completion options. It then steps through a fixed series of stages. First comes an optional pre-transfer semaphore gate. Next the block issues the transfer to a DMA engine over a valid/ready handshake and waits for that engine to report it done. After that come optional post-transfer semaphore work and an optional doorbell write. Last come an optional response element, tagged with the request identifier, and a one-cycle message-signalled interrupt pulse.

The semaphore units, the doorbell writer, the DMA engine and the response queue are neighbours. Each one is reached only through a request/acknowledge or valid/ready pair. Two counters of transfers in flight, one per direction, are exported so that a fence unit can read them. The descriptor's sequence field is not taken in by this block at all, since it plays no part in sequencing.

Top module: `dma_req_sequencer`

## Requirements
- R1: Command bits [1:0] select the transfer kind: 1 issues a transfer with `dma_to_dev` high, 2 issues one with `dma_to_dev` low. The descriptor's source, destination and length appear unchanged on the DMA port.
- R2: Command bit 3 drives `dma_bulk`: 1 means a bulk copy, 0 means a linked-list walk, in which case `dma_src` carries the list address.
- R3: When command bit 4 is 1, exactly one response element is presented once the other stages finish. It carries the request ID and completion code 0x0000 for a legal request.
- R4: Command bit 7 raises `msi_pulse` at completion only while `cfg_force_irq_en` is 1, and it does so even when no response is written. With the input at 0 the bit has no effect.
- R5: The length path is 32 bits wide, so 0xFFFFFFFF passes through unchanged.
- R6: Command bits 2, 5 and 6 change nothing at the ports.
- R7: Command kind 3 issues no transfer and starts no semaphore or doorbell stage. It always yields a response, with code 0x0001.
- R8: Command kind 0 issues no transfer, but the requested semaphore, doorbell and response stages still run.
- R9: The stages run in this order, one at a time: pre-sync gate, DMA issue and completion, post-sync semaphore, doorbell, response, MSI.
- R10: `busy_to_dev` and `busy_from_dev` each rise by one when a transfer of that direction is accepted and fall by one when it reports done.
- R11: When `cfg_rsp_irq_en` is 1, a request that writes a response also pulses `msi_pulse` for one cycle, in the cycle after its final handshake. A request that writes no response and has no forced interrupt gives no pulse.
- R12: After reset every request, valid and pulse output is low, both counters are zero and `req_ready` is high. `req_ready` is high only while the block is idle, and a stalled `dma_valid` or `rsp_valid` holds its payload until accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_force_irq_en | input | 1 | Honour the forced-interrupt command bit |
| cfg_rsp_irq_en | input | 1 | Pulse the interrupt whenever a response is written |
| req_valid | input | 1 | Request descriptor present |
| req_ready | output | 1 | Block idle, descriptor accepted this cycle |
| req_id | input | 16 | Request identifier |
| req_cmd | input | 8 | Packed command byte |
| req_src | input | 64 | Source address or list address |
| req_dst | input | 64 | Destination address |
| req_len | input | 32 | Transfer length in bytes |
| req_presync | input | 1 | Descriptor carries a pre-transfer semaphore gate |
| req_postsync | input | 1 | Descriptor carries post-transfer semaphore work |
| req_bell | input | 1 | Descriptor asks for a doorbell write |
| sem_pre_req | output | 1 | Pre-sync gate request |
| sem_pre_ack | input | 1 | Pre-sync gate satisfied |
| dma_valid | output | 1 | Transfer command valid |
| dma_ready | input | 1 | DMA engine accepts the command |
| dma_to_dev | output | 1 | 1: host to device, 0: device to host |
| dma_bulk | output | 1 | 1: bulk copy, 0: linked-list walk |
| dma_src | output | 64 | Source or list address |
| dma_dst | output | 64 | Destination address |
| dma_len | output | 32 | Transfer length |
| dma_done | input | 1 | Accepted transfer has finished |
| sem_post_req | output | 1 | Post-sync semaphore request |
| sem_post_ack | input | 1 | Post-sync semaphore work finished |
| bell_req | output | 1 | Doorbell write request |
| bell_ack | input | 1 | Doorbell written |
| rsp_valid | output | 1 | Response element valid |
| rsp_ready | input | 1 | Response queue accepts the element |
| rsp_id | output | 16 | Request identifier of the response |
| rsp_code | output | 16 | Completion code |
| msi_pulse | output | 1 | One-cycle interrupt pulse |
| busy_to_dev | output | 4 | Host-to-device transfers in flight |
| busy_from_dev | output | 4 | Device-to-host transfers in flight |

## Verification
A corrupted sequencer state shows up in the order of the neighbour handshakes. If a stage is skipped, repeated or run early, the request or valid line of the wrong neighbour rises within the cycle after the previous acknowledge. A mis-decoded command byte shows up at the DMA port in the first cycle after acceptance, as a wrong direction or mode flag or as a transfer that should not exist. A counter that fails to return to zero is visible on the busy outputs as soon as the request completes. A wrong interrupt decision is visible exactly one cycle after the final handshake.

// File: rtl/dmaseq_pkg.sv
// Shared types for the DMA request descriptor sequencer.
// Assumes an 8-bit command byte whose bit layout is fixed by the descriptor
// producer: kind in [1:0], mode in 3, response in 4, forced interrupt in 7.
package dmaseq_pkg;

    localparam int unsigned CMD_W = 8;

    // Masks of the live command fields; all other bits are reserved.
    localparam logic [CMD_W-1:0] KIND_MASK  = 8'h03;
    localparam logic [CMD_W-1:0] BULK_MASK  = 8'h08;
    localparam logic [CMD_W-1:0] RSP_MASK   = 8'h10;
    localparam logic [CMD_W-1:0] FIRQ_MASK  = 8'h80;

    localparam int unsigned CC_OK       = 0;
    localparam int unsigned CC_BAD_KIND = 1;

    typedef enum logic [1:0] {
        XFER_NONE     = 2'd0,
        XFER_TO_DEV   = 2'd1,
        XFER_FROM_DEV = 2'd2,
        XFER_BAD      = 2'd3
    } xfer_kind_e;

    typedef struct packed {
        xfer_kind_e kind;
        logic       moves_data;
        logic       bulk;
        logic       want_rsp;
        logic       force_irq;
        logic       bad;
    } cmd_info_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRE,
        ST_ISSUE,
        ST_WAIT,
        ST_POST,
        ST_BELL,
        ST_RESP
    } seq_state_e;

endpackage

// File: rtl/dmaseq_cmd_decode.sv
// Command byte decoder.
// Turns the packed command byte into the flags the sequencer acts on.
// Purely combinational; reserved bits are masked away and never reach a flag.
module dmaseq_cmd_decode
    import dmaseq_pkg::*;
(
    input  logic [CMD_W-1:0] cmd,
    output cmd_info_t        info
);

    logic [1:0] kind_bits;

    // Field extraction through the live-bit masks.
    always_comb begin
        kind_bits       = 2'(cmd & KIND_MASK);
        info.kind       = xfer_kind_e'(kind_bits);
        info.bad        = (kind_bits == 2'd3);
        info.moves_data = (kind_bits == 2'd1) || (kind_bits == 2'd2);
        info.bulk       = |(cmd & BULK_MASK);
        info.force_irq  = |(cmd & FIRQ_MASK);
        info.want_rsp   = (|(cmd & RSP_MASK)) || info.bad;
    end

endmodule

// File: rtl/dmaseq_outstanding.sv
// Up/down counter of transfers in flight for one direction.
// Assumes the sequencer never retires more transfers than it issued;
// the checks below guard both ends of the range.
module dmaseq_outstanding #(
    parameter int unsigned CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             dec,
    output logic [CNT_W-1:0] count
);

    // Track issue and retirement; simultaneous events cancel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
        end else if (inc && !dec) begin
            count <= count + 1'b1;
        end else if (dec && !inc) begin
            count <= count - 1'b1;
        end
    end

    p_no_underflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !inc) |-> (count != '0));

    p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !dec) |-> (count != '1));

endmodule

// File: rtl/dma_req_sequencer.sv
// DMA request descriptor sequencer.
// Accepts one descriptor when idle and walks it through the pre-sync gate,
// DMA issue and completion, post-sync semaphore, doorbell, response and
// interrupt stages, skipping the ones the descriptor does not ask for.
// Assumes each neighbour holds its acknowledge for one cycle per request and
// that the DMA engine reports done only for an accepted transfer.
module dma_req_sequencer
    import dmaseq_pkg::*;
#(
    parameter int unsigned ADDR_W = 64,
    parameter int unsigned LEN_W  = 32,
    parameter int unsigned ID_W   = 16,
    parameter int unsigned CODE_W = 16,
    parameter int unsigned CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_force_irq_en,
    input  logic              cfg_rsp_irq_en,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ID_W-1:0]   req_id,
    input  logic [CMD_W-1:0]  req_cmd,
    input  logic [ADDR_W-1:0] req_src,
    input  logic [ADDR_W-1:0] req_dst,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_presync,
    input  logic              req_postsync,
    input  logic              req_bell,
    output logic              sem_pre_req,
    input  logic              sem_pre_ack,
    output logic              dma_valid,
    input  logic              dma_ready,
    output logic              dma_to_dev,
    output logic              dma_bulk,
    output logic [ADDR_W-1:0] dma_src,
    output logic [ADDR_W-1:0] dma_dst,
    output logic [LEN_W-1:0]  dma_len,
    input  logic              dma_done,
    output logic              sem_post_req,
    input  logic              sem_post_ack,
    output logic              bell_req,
    input  logic              bell_ack,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [ID_W-1:0]   rsp_id,
    output logic [CODE_W-1:0] rsp_code,
    output logic              msi_pulse,
    output logic [CNT_W-1:0]  busy_to_dev,
    output logic [CNT_W-1:0]  busy_from_dev
);

    localparam int unsigned NUM_DIR = 2;

    seq_state_e        state_q, state_d;
    logic              idle, accept, finish;
    logic [ID_W-1:0]   id_q;
    logic [CMD_W-1:0]  cmd_q, cmd_sel;
    logic [ADDR_W-1:0] src_q, dst_q;
    logic [LEN_W-1:0]  len_q;
    logic              pre_q, post_q, bell_q;
    logic              pre_sel, post_sel, bell_sel;
    logic              en_pre, en_xfer, en_post, en_bell, en_rsp;
    seq_state_e        after_bell, after_post, after_xfer, after_pre, from_idle;
    logic              msi_q;
    logic              issue_fire, retire_fire;
    cmd_info_t         info;

    assign idle      = (state_q == ST_IDLE);
    assign accept    = req_valid && idle;
    assign req_ready = idle;

    // While idle the incoming descriptor is decoded, otherwise the held one.
    assign cmd_sel  = idle ? req_cmd      : cmd_q;
    assign pre_sel  = idle ? req_presync  : pre_q;
    assign post_sel = idle ? req_postsync : post_q;
    assign bell_sel = idle ? req_bell     : bell_q;

    dmaseq_cmd_decode u_decode (
        .cmd  (cmd_sel),
        .info (info)
    );

    // Stage enables; an illegal kind suppresses every optional stage.
    assign en_pre  = pre_sel  && !info.bad;
    assign en_xfer = info.moves_data;
    assign en_post = post_sel && !info.bad;
    assign en_bell = bell_sel && !info.bad;
    assign en_rsp  = info.want_rsp;

    // Skip chain: the first enabled stage after each point in the order.
    assign after_bell = en_rsp  ? ST_RESP  : ST_IDLE;
    assign after_post = en_bell ? ST_BELL  : after_bell;
    assign after_xfer = en_post ? ST_POST  : after_post;
    assign after_pre  = en_xfer ? ST_ISSUE : after_xfer;
    assign from_idle  = en_pre  ? ST_PRE   : after_pre;

    // Next-state selection driven by each neighbour's acknowledge.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:  if (accept)       state_d = from_idle;
            ST_PRE:   if (sem_pre_ack)  state_d = after_pre;
            ST_ISSUE: if (dma_ready)    state_d = ST_WAIT;
            ST_WAIT:  if (dma_done)     state_d = after_xfer;
            ST_POST:  if (sem_post_ack) state_d = after_post;
            ST_BELL:  if (bell_ack)     state_d = after_bell;
            ST_RESP:  if (rsp_ready)    state_d = ST_IDLE;
            default:                    state_d = ST_IDLE;
        endcase
    end

    // A request finishes when the block returns to idle, including same-cycle.
    assign finish = (state_d == ST_IDLE) && (!idle || accept);

    // Sequencer state register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Descriptor capture on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            id_q   <= '0;
            cmd_q  <= '0;
            src_q  <= '0;
            dst_q  <= '0;
            len_q  <= '0;
            pre_q  <= 1'b0;
            post_q <= 1'b0;
            bell_q <= 1'b0;
        end else if (accept) begin
            id_q   <= req_id;
            cmd_q  <= req_cmd;
            src_q  <= req_src;
            dst_q  <= req_dst;
            len_q  <= req_len;
            pre_q  <= req_presync;
            post_q <= req_postsync;
            bell_q <= req_bell;
        end
    end

    // Interrupt decision at completion, presented one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) msi_q <= 1'b0;
        else        msi_q <= finish && ((cfg_rsp_irq_en && en_rsp) ||
                                        (cfg_force_irq_en && info.force_irq));
    end

    assign sem_pre_req  = (state_q == ST_PRE);
    assign dma_valid    = (state_q == ST_ISSUE);
    assign sem_post_req = (state_q == ST_POST);
    assign bell_req     = (state_q == ST_BELL);
    assign rsp_valid    = (state_q == ST_RESP);
    assign dma_to_dev   = (info.kind == XFER_TO_DEV);
    assign dma_bulk     = info.bulk;
    assign dma_src      = src_q;
    assign dma_dst      = dst_q;
    assign dma_len      = len_q;
    assign rsp_id       = id_q;
    assign rsp_code     = info.bad ? CODE_W'(CC_BAD_KIND) : CODE_W'(CC_OK);
    assign msi_pulse    = msi_q;

    assign issue_fire  = dma_valid && dma_ready;
    assign retire_fire = (state_q == ST_WAIT) && dma_done;

    logic [NUM_DIR-1:0] cnt_inc, cnt_dec;
    logic [CNT_W-1:0]   cnt_val [NUM_DIR];

    // One in-flight counter per direction: index 0 to device, 1 from device.
    for (genvar g = 0; g < NUM_DIR; g++) begin : g_dir
        localparam logic DIR_TO = (g == 0);
        assign cnt_inc[g] = issue_fire  && (dma_to_dev == DIR_TO);
        assign cnt_dec[g] = retire_fire && (dma_to_dev == DIR_TO);
        dmaseq_outstanding #(.CNT_W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (cnt_inc[g]),
            .dec   (cnt_dec[g]),
            .count (cnt_val[g])
        );
    end

    assign busy_to_dev   = cnt_val[0];
    assign busy_from_dev = cnt_val[1];

    p_dma_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_valid && !dma_ready) |=> (dma_valid && $stable(dma_src) &&
                                       $stable(dma_len) && $stable(dma_to_dev)));

    p_rsp_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_id) && $stable(rsp_code)));

    p_no_bad_dma_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dma_valid |-> !info.bad);

    p_bell_after_post_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(bell_req) && post_q) |-> $past(sem_post_req));

    p_msi_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        msi_pulse |-> $past(cfg_rsp_irq_en || cfg_force_irq_en));

    p_busy_after_issue_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_fire && dma_to_dev) |=> (busy_to_dev != '0));

endmodule

// File: tb/dma_req_sequencer_tb.sv
`timescale 1ns/1ps
module dma_req_sequencer_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_force_irq_en, cfg_rsp_irq_en;
    logic        req_valid, req_ready;
    logic [15:0] req_id;
    logic [7:0]  req_cmd;
    logic [63:0] req_src, req_dst;
    logic [31:0] req_len;
    logic        req_presync, req_postsync, req_bell;
    logic        sem_pre_req, sem_pre_ack;
    logic        dma_valid, dma_ready, dma_to_dev, dma_bulk, dma_done;
    logic [63:0] dma_src, dma_dst;
    logic [31:0] dma_len;
    logic        sem_post_req, sem_post_ack, bell_req, bell_ack;
    logic        rsp_valid, rsp_ready;
    logic [15:0] rsp_id, rsp_code;
    logic        msi_pulse;
    logic [3:0]  busy_to_dev, busy_from_dev;

    always #2.5 clk = ~clk;

    dma_req_sequencer u_dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_force_irq_en(cfg_force_irq_en), .cfg_rsp_irq_en(cfg_rsp_irq_en),
        .req_valid(req_valid), .req_ready(req_ready), .req_id(req_id),
        .req_cmd(req_cmd), .req_src(req_src), .req_dst(req_dst), .req_len(req_len),
        .req_presync(req_presync), .req_postsync(req_postsync), .req_bell(req_bell),
        .sem_pre_req(sem_pre_req), .sem_pre_ack(sem_pre_ack),
        .dma_valid(dma_valid), .dma_ready(dma_ready), .dma_to_dev(dma_to_dev),
        .dma_bulk(dma_bulk), .dma_src(dma_src), .dma_dst(dma_dst), .dma_len(dma_len),
        .dma_done(dma_done), .sem_post_req(sem_post_req), .sem_post_ack(sem_post_ack),
        .bell_req(bell_req), .bell_ack(bell_ack), .rsp_valid(rsp_valid),
        .rsp_ready(rsp_ready), .rsp_id(rsp_id), .rsp_code(rsp_code),
        .msi_pulse(msi_pulse), .busy_to_dev(busy_to_dev), .busy_from_dev(busy_from_dev)
    );

    typedef struct packed {
        logic [15:0] id;
        logic [7:0]  cmd;
        logic        pre, post, bell, fcfg, rcfg;
        logic [63:0] src, dst;
        logic [31:0] len;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{16'h0011, 8'h19, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 64'h1000, 64'h2000, 32'h100},
        '{16'h0022, 8'h12, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 64'h000000AB00000040, 64'h0, 32'h40},
        '{16'h0033, 8'h89, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 64'h3000, 64'h4000, 32'h8},
        '{16'h0044, 8'h89, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 64'h3000, 64'h4000, 32'h8},
        '{16'h0055, 8'h0B, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 64'h5000, 64'h6000, 32'h10},
        '{16'h0066, 8'h10, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 64'h0, 64'h0, 32'h0},
        '{16'h0077, 8'h6D, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 64'hFFFFFFFFFFFFF000,
          64'h8000000000000000, 32'hFFFFFFFF},
        '{16'h0088, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 64'h0, 64'h0, 32'h0}
    };

    int n_checks = 0;
    int n_err    = 0;

    // Observations from one request.
    int          steps [6];   // pre, dma, post, bell, rsp, msi
    int          n_dma, n_rsp, n_msi, n_pre, n_post, n_bell;
    logic        o_to_dev, o_bulk;
    logic [63:0] o_src, o_dst;
    logic [31:0] o_len;
    logic [15:0] o_id, o_code;
    logic [3:0]  w_to, w_from;
    int          hold_bad, ready_busy;

    task automatic check_eq(input string tag, input string what,
                            input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Drive one descriptor and act as every neighbour for a fixed window.
    task automatic run_one(input vec_t v, input int dma_stall, input int rsp_stall);
        int  dstall = dma_stall;
        int  rstall = rsp_stall;
        logic hs_prev = 1'b0;
        for (int i = 0; i < 6; i++) steps[i] = -1;
        n_dma = 0; n_rsp = 0; n_msi = 0; n_pre = 0; n_post = 0; n_bell = 0;
        hold_bad = 0; ready_busy = 0; w_to = '0; w_from = '0;
        @(negedge clk);
        cfg_force_irq_en = v.fcfg; cfg_rsp_irq_en = v.rcfg;
        req_id = v.id; req_cmd = v.cmd; req_src = v.src; req_dst = v.dst;
        req_len = v.len; req_presync = v.pre; req_postsync = v.post; req_bell = v.bell;
        req_valid = 1'b1;
        for (int k = 1; k <= 24; k++) begin
            @(negedge clk);
            req_valid = 1'b0;
            dma_done  = hs_prev;
            if (hs_prev) begin
                w_to = busy_to_dev; w_from = busy_from_dev;
            end
            hs_prev = 1'b0;
            sem_pre_ack = sem_pre_req;
            if (sem_pre_req) begin n_pre++; if (steps[0] < 0) steps[0] = k; end
            sem_post_ack = sem_post_req;
            if (sem_post_req) begin n_post++; if (steps[2] < 0) steps[2] = k; end
            bell_ack = bell_req;
            if (bell_req) begin n_bell++; if (steps[3] < 0) steps[3] = k; end
            if ((sem_pre_req || dma_valid || sem_post_req || bell_req || rsp_valid) && req_ready)
                ready_busy++;
            if (dma_valid) begin
                if (dma_src !== v.src || dma_len !== v.len) hold_bad++;
                if (dstall > 0) begin
                    dma_ready = 1'b0; dstall--;
                end else begin
                    dma_ready = 1'b1; hs_prev = 1'b1; n_dma++; steps[1] = k;
                    o_to_dev = dma_to_dev; o_bulk = dma_bulk; o_src = dma_src;
                    o_dst = dma_dst; o_len = dma_len;
                end
            end else begin
                dma_ready = 1'b0;
            end
            if (rsp_valid) begin
                if (rsp_id !== v.id) hold_bad++;
                if (rstall > 0) begin
                    rsp_ready = 1'b0; rstall--;
                end else begin
                    rsp_ready = 1'b1; n_rsp++; steps[4] = k;
                    o_id = rsp_id; o_code = rsp_code;
                end
            end else begin
                rsp_ready = 1'b0;
            end
            if (msi_pulse) begin n_msi++; steps[5] = k; end
        end
    endtask

    // Expected results derived from the command byte and flags.
    task automatic verify(input vec_t v, input string lbl);
        logic [1:0] kind = v.cmd[1:0];
        logic bad   = (kind == 2'd3);
        logic moves = (kind == 2'd1) || (kind == 2'd2);
        logic ersp  = v.cmd[4] || bad;
        logic emsi  = (v.rcfg && ersp) || (v.fcfg && v.cmd[7]);
        int   last  = 0;
        check_eq(bad ? "R7" : (moves ? "R1" : "R8"), {lbl, " transfer count"}, 64'(n_dma), 64'(moves));
        if (moves) begin
            check_eq("R1", {lbl, " direction"}, 64'(o_to_dev), 64'(kind == 2'd1));
            check_eq("R2", {lbl, " bulk flag"}, 64'(o_bulk), 64'(v.cmd[3]));
            check_eq("R2", {lbl, " source"}, o_src, v.src);
            check_eq("R1", {lbl, " destination"}, o_dst, v.dst);
            check_eq("R5", {lbl, " length"}, 64'(o_len), 64'(v.len));
            check_eq("R10", {lbl, " in flight to device"}, 64'(w_to), 64'(kind == 2'd1));
            check_eq("R10", {lbl, " in flight from device"}, 64'(w_from), 64'(kind == 2'd2));
        end
        check_eq("R10", {lbl, " counters drained"}, 64'({busy_to_dev, busy_from_dev}), 64'(0));
        check_eq(bad ? "R7" : "R8", {lbl, " pre gate"}, 64'(n_pre), 64'(v.pre && !bad));
        check_eq(bad ? "R7" : "R8", {lbl, " post sem"}, 64'(n_post), 64'(v.post && !bad));
        check_eq(bad ? "R7" : "R8", {lbl, " doorbell"}, 64'(n_bell), 64'(v.bell && !bad));
        check_eq("R3", {lbl, " response count"}, 64'(n_rsp), 64'(ersp));
        if (ersp) begin
            check_eq("R3", {lbl, " response id"}, 64'(o_id), 64'(v.id));
            check_eq(bad ? "R7" : "R3", {lbl, " response code"}, 64'(o_code), bad ? 64'h1 : 64'h0);
        end
        check_eq((v.cmd[7] && !ersp) ? "R4" : "R11", {lbl, " interrupt count"}, 64'(n_msi), 64'(emsi));
        for (int i = 0; i < 6; i++) begin
            if (steps[i] >= 0) begin
                check_eq("R9", {lbl, " stage order"}, 64'(steps[i] > last), 64'(1));
                last = steps[i];
            end
        end
        if (ersp && emsi)
            check_eq("R11", {lbl, " interrupt one cycle after response"},
                     64'(steps[5] - steps[4]), 64'(1));
        check_eq("R12", {lbl, " ready low while busy"}, 64'(ready_busy), 64'(0));
        check_eq("R12", {lbl, " payload held"}, 64'(hold_bad), 64'(0));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        vec_t d;
        rst_n = 1'b0; req_valid = 1'b0; req_id = '0; req_cmd = '0; req_src = '0;
        req_dst = '0; req_len = '0; req_presync = 1'b0; req_postsync = 1'b0;
        req_bell = 1'b0; sem_pre_ack = 1'b0; dma_ready = 1'b0; dma_done = 1'b0;
        sem_post_ack = 1'b0; bell_ack = 1'b0; rsp_ready = 1'b0;
        cfg_force_irq_en = 1'b0; cfg_rsp_irq_en = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R12 reset state
        check_eq("R12", "reset ready", 64'(req_ready), 64'(1));
        check_eq("R12", "reset handshakes",
                 64'({sem_pre_req, dma_valid, sem_post_req, bell_req, rsp_valid, msi_pulse}), 64'(0));
        check_eq("R12", "reset counters", 64'({busy_to_dev, busy_from_dev}), 64'(0));

        // Table walk.
        for (int n = 0; n < NV; n++) begin
            run_one(VECS[n], 0, 0);
            verify(VECS[n], $sformatf("vec%0d", n));
        end

        // R12 backpressure on both DMA and response ports.
        d = VECS[1];
        run_one(d, 3, 3);
        verify(d, "stall");

        // R6 reserved bits alone do not change a legal from-device request.
        d = VECS[1];
        d.cmd = d.cmd | 8'h64;
        run_one(d, 0, 0);
        verify(d, "rsvd R6");

        // R4 forced interrupt with an illegal kind and response interrupts off.
        d = VECS[4];
        d.cmd = 8'h83; d.fcfg = 1'b1;
        run_one(d, 0, 1);
        verify(d, "force R4");

        @(negedge clk);
        check_eq("R12", "idle after sequence", 64'(req_ready), 64'(1));
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule